// File: doc/BRIEF.md
# Crossover Interlock Safety Rule Monitor

This block watches a track-section controller from the outside. On every evaluation strobe it samples the controller's inputs and outputs. These are the two crossover point positions, the occupancy of a row of track circuits, the four signal aspects, the two point-lock outputs, the speed-code enables of the transmitters between circuits and the high-speed approach codes. It then decides whether a safety rule has been broken. Each rule has the form "a condition seen at strobe i forces a safe state at strobe i+k", with k equal to 0 for the invariants, 1 for the point and lock rules, and 2 for the transmitter occupancy rules. A rule that is re-evaluated on every strobe also keeps the safe state in force for as long as its condition persists.

A four-state machine sequences the checking. It has the states BOOT, WARM, RUN and TRIP. The transitions are:
- BOOT_TO_WARM on the first strobe after reset, with nothing checked.
- WARM_TO_RUN on the second strobe when no rule fails; the invariants and depth-1 rules are checked on that strobe.
- WARM_TO_TRIP on the second strobe when a rule fails.
- RUN_TO_TRIP on a later strobe when a rule fails; in RUN the depth-2 rules are checked as well.
- TRIP_HOLD, which keeps the machine in TRIP until reset.

On the trip the block records the lowest-numbered failing rule and the strobe index at which it failed.

Top module: `smon_top`

## Requirements
- R1: After reset `trip` is 0 and `trip_rule` and `trip_cycle` are 0.
- R2: Strobe index 0 (the first strobe after reset) never raises `trip`, whatever the inputs.
- R3: From strobe 1 on, signals 0 and 1 both on raises rule 0, and signals 2 and 3 both on raises rule 1, on the same strobe.
- R4: From strobe 1 on, a signal s (0..3) that is off while `hi_spd[s]` is 1 raises rule 2+s.
- R5: Point p (0 or 1) reversed at strobe i-1 with signal 2p or 2p+1 on at strobe i raises rule 6+p, for i >= 1.
- R6: Any signal on at strobe i-1 with any `pt_release` bit at 1 (1 = unlocked) at strobe i raises rule 8, for i >= 1.
- R7: Circuits t and t+1 both occupied (`occ` bit 1 = occupied) at strobe i-2 with `tx_code[t]` at 1 at strobe i raises rule 9+t, checked only for i >= 2.
- R8: When several rules fail on one strobe, `trip_rule` holds the lowest rule number.
- R9: Once `trip` is 1, it, `trip_rule` and `trip_cycle` stay unchanged until reset.
- R10: A condition held over several strobes requires the safe state on every later strobe, not only on the first.
- R11: Clocks without `strobe` neither evaluate rules nor advance the history.
- R12: `trip_cycle` holds the 0-based strobe index, counted since reset and saturating, of the strobe that failed; the outputs change on the clock edge that samples that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | One controller evaluation cycle completed; sample now |
| pt_rev | input | 2 | Point p is in reverse (1) |
| occ | input | NTX+1 | Track circuit occupied (1) |
| sig_on | input | 4 | Signal aspect on (1); 0/1 and 2/3 are opposing pairs |
| hi_spd | input | 4 | High-speed code on the approach to signal s |
| pt_release | input | 2 | Point lock released (1) or locked (0) |
| tx_code | input | NTX | Speed code enabled on the transmitter between circuits t and t+1 |
| trip | output | 1 | Sticky violation flag |
| trip_rule | output | clog2(NTX+9) | Number of the first failing rule |
| trip_cycle | output | CW | Strobe index of the failure |

## Verification
A history register that slips by one strobe moves every depth-1 and depth-2 failure to the wrong strobe. This shows at the ports within one or two strobes, either as a missing trip or as a trip whose `trip_cycle` is off by one. A mis-sequenced state machine shows on the very first strobes after reset, as a trip at index 0 or 1 where the warm-up should have masked it, or as no trip where it should not have. A wrong priority or a capture that is not sticky shows as a changed `trip_rule` on the strobe after the trip. The bench's reference model compares all three outputs on every clock, so each of these errors appears in the cycle it occurs.

// File: rtl/smon_pkg.sv
package smon_pkg;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_WARM = 2'd1,
        ST_RUN  = 2'd2,
        ST_TRIP = 2'd3
    } mon_state_t;

    localparam int N_SIG       = 4;
    localparam int N_PT        = 2;
    localparam int R_OPP_AB    = 0;
    localparam int R_OPP_CD    = 1;
    localparam int R_SLOW_BASE = 2;
    localparam int R_PT_BASE   = R_SLOW_BASE + N_SIG;
    localparam int R_LOCK      = R_PT_BASE + N_PT;
    localparam int R_TX_BASE   = R_LOCK + 1;
    localparam int N_D1        = N_PT + 1;

    function automatic int rule_count(input int ntx);
        return R_TX_BASE + ntx;
    endfunction

endpackage

// File: rtl/smon_delay.sv
module smon_delay #(
    parameter int W = 1,
    parameter int K = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [K];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < K; s++) stg[s] <= '0;
        end else if (adv) begin
            stg[0] <= din;
            for (int s = 1; s < K; s++) stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[K-1];
endmodule

// File: rtl/smon_rules.sv
module smon_rules
    import smon_pkg::*;
#(
    parameter int NTX = 4,
    parameter int NR  = rule_count(NTX)
) (
    input  logic [N_SIG-1:0] sig_on,
    input  logic [N_SIG-1:0] hi_spd,
    input  logic [N_PT-1:0]  pt_release,
    input  logic [NTX-1:0]   tx_code,
    input  logic [N_D1-1:0]  d1_cond,
    input  logic [NTX-1:0]   d2_pair,
    output logic [NR-1:0]    fail_raw
);
    // invariants: opposing aspects never on together
    assign fail_raw[R_OPP_AB] = sig_on[0] & sig_on[1];
    assign fail_raw[R_OPP_CD] = sig_on[2] & sig_on[3];

    // invariants: a stop aspect needs a low approach code
    for (genvar s = 0; s < N_SIG; s++) begin : g_slow
        assign fail_raw[R_SLOW_BASE+s] = ~sig_on[s] & hi_spd[s];
    end

    // depth 1: a reversed point clears its signal pair
    for (genvar p = 0; p < N_PT; p++) begin : g_point
        assign fail_raw[R_PT_BASE+p] = d1_cond[p] & (sig_on[2*p] | sig_on[2*p+1]);
    end

    // depth 1: an aspect on demands both locks engaged
    assign fail_raw[R_LOCK] = d1_cond[N_PT] & (|pt_release);

    // depth 2: an occupied pair silences the transmitter between them
    for (genvar t = 0; t < NTX; t++) begin : g_tx
        assign fail_raw[R_TX_BASE+t] = d2_pair[t] & tx_code[t];
    end
endmodule

// File: rtl/smon_prio.sv
module smon_prio #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/smon_top.sv
module smon_top
    import smon_pkg::*;
#(
    parameter int NTX = 4,
    parameter int CW  = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   strobe,
    input  logic [1:0]                             pt_rev,
    input  logic [NTX:0]                           occ,
    input  logic [3:0]                             sig_on,
    input  logic [3:0]                             hi_spd,
    input  logic [1:0]                             pt_release,
    input  logic [NTX-1:0]                         tx_code,
    output logic                                   trip,
    output logic [$clog2(rule_count(NTX))-1:0]     trip_rule,
    output logic [CW-1:0]                          trip_cycle
);
    localparam int NR = rule_count(NTX);
    localparam int RW = $clog2(NR);

    mon_state_t    state_q, state_d;
    logic [CW-1:0] scnt_q;
    logic [N_D1-1:0] d1_in, d1_q;
    logic [NTX-1:0]  d2_in, d2_q;
    logic [NR-1:0]   fail_raw, en, fail;
    logic            any_fail;
    logic [RW-1:0]   first_idx;
    logic            capture;

    // condition terms that feed the history lines
    assign d1_in = {|sig_on, pt_rev};
    for (genvar t = 0; t < NTX; t++) begin : g_pair
        assign d2_in[t] = occ[t] & occ[t+1];
    end

    smon_delay #(.W(N_D1), .K(1)) u_d1 (
        .clk(clk), .rst_n(rst_n), .adv(strobe), .din(d1_in), .dout(d1_q)
    );

    smon_delay #(.W(NTX), .K(2)) u_d2 (
        .clk(clk), .rst_n(rst_n), .adv(strobe), .din(d2_in), .dout(d2_q)
    );

    smon_rules #(.NTX(NTX), .NR(NR)) u_rules (
        .sig_on(sig_on), .hi_spd(hi_spd), .pt_release(pt_release),
        .tx_code(tx_code), .d1_cond(d1_q), .d2_pair(d2_q), .fail_raw(fail_raw)
    );

    assign fail = fail_raw & en;

    smon_prio #(.N(NR), .IW(RW)) u_prio (
        .req(fail), .any(any_fail), .idx(first_idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: if (strobe) state_d = ST_WARM;
            ST_WARM: if (strobe) state_d = any_fail ? ST_TRIP : ST_RUN;
            ST_RUN:  if (strobe && any_fail) state_d = ST_TRIP;
            ST_TRIP: state_d = ST_TRIP;
            default: state_d = ST_BOOT;
        endcase
    end

    // outputs of the machine: rule enables and the flag
    always_comb begin
        en   = '0;
        trip = 1'b0;
        unique case (state_q)
            ST_BOOT: en = '0;
            ST_WARM: for (int r = 0; r < R_TX_BASE; r++) en[r] = 1'b1;
            ST_RUN:  en = '1;
            ST_TRIP: trip = 1'b1;
            default: en = '0;
        endcase
    end

    assign capture = strobe && any_fail && (state_q == ST_WARM || state_q == ST_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt_q     <= '0;
            trip_rule  <= '0;
            trip_cycle <= '0;
        end else begin
            if (strobe && scnt_q != {CW{1'b1}}) scnt_q <= scnt_q + 1'b1;
            if (capture) begin
                trip_rule  <= first_idx;
                trip_cycle <= scnt_q;
            end
        end
    end
endmodule

// File: rtl/smon_checker.sv
module smon_checker
    import smon_pkg::*;
#(
    parameter int NTX = 4,
    parameter int CW  = 16
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               strobe,
    input logic [3:0]                         sig_on,
    input logic                               trip,
    input logic [$clog2(rule_count(NTX))-1:0] trip_rule,
    input logic [CW-1:0]                      trip_cycle
);
    localparam int NR = rule_count(NTX);
    logic [31:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (strobe && cnt_q < 32'd1000) cnt_q <= cnt_q + 1;
    end

    assert_boot_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == 0 && strobe) |=> !trip);

    assert_opposing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cnt_q >= 1 && !trip && sig_on[0] && sig_on[1]) |=> trip);

    assert_rule_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> (int'(trip_rule) < NR));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (trip && $stable(trip_rule) && $stable(trip_cycle)));

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !trip) |=> !trip);

    assert_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(trip) && cnt_q < 32'd1000) |-> (32'(trip_cycle) == cnt_q - 1));
endmodule

bind smon_top smon_checker #(.NTX(NTX), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sig_on(sig_on),
    .trip(trip), .trip_rule(trip_rule), .trip_cycle(trip_cycle)
);

// File: tb/tb_smon_top.sv
`timescale 1ns/1ps
module tb_smon_top;
    localparam int NTX = 4;
    localparam int NC  = NTX + 1;
    localparam int NR  = 9 + NTX;
    localparam int CW  = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic strobe = 0;
    logic [1:0] pr = 0, rel = 0;
    logic [NC-1:0] oc = 0;
    logic [3:0] sig = 0, hi = 0;
    logic [NTX-1:0] tx = 0;
    logic trip;
    logic [3:0] trip_rule;
    logic [CW-1:0] trip_cycle;

    int errs = 0;
    int checks = 0;

    always #4 clk = ~clk;

    smon_top #(.NTX(NTX), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .pt_rev(pr), .occ(oc),
        .sig_on(sig), .hi_spd(hi), .pt_release(rel), .tx_code(tx),
        .trip(trip), .trip_rule(trip_rule), .trip_cycle(trip_cycle)
    );

    // behavioural reference: history kept as plain previous-sample copies
    bit m_trip;
    int m_rule, m_cyc, m_n;
    logic [1:0] p1_pr;
    logic [3:0] p1_sig;
    logic [NC-1:0] p1_oc, p2_oc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_trip = 0; m_rule = 0; m_cyc = 0; m_n = 0;
            p1_pr = 0; p1_sig = 0; p1_oc = 0; p2_oc = 0;
        end else if (strobe) begin
            int first;
            first = -1;
            if (!m_trip) begin
                for (int r = 0; r < NR; r++) begin
                    bit f;
                    if (r == 0)      f = m_n >= 1 && sig[0] && sig[1];
                    else if (r == 1) f = m_n >= 1 && sig[2] && sig[3];
                    else if (r < 6)  f = m_n >= 1 && !sig[r-2] && hi[r-2];
                    else if (r < 8)  f = m_n >= 1 && p1_pr[r-6] && (sig[2*(r-6)] || sig[2*(r-6)+1]);
                    else if (r == 8) f = m_n >= 1 && (p1_sig != 0) && (rel != 0);
                    else             f = m_n >= 2 && p2_oc[r-9] && p2_oc[r-8] && tx[r-9];
                    if (f && first < 0) first = r;
                end
                if (first >= 0) begin
                    m_trip = 1; m_rule = first; m_cyc = m_n;
                end
            end
            m_n++;
            p2_oc = p1_oc; p1_oc = oc; p1_sig = sig; p1_pr = pr;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("model(R12) trip", int'(trip), int'(m_trip));
            chk("model(R8) rule", int'(trip_rule), m_rule);
            chk("model(R12) cycle", int'(trip_cycle), m_cyc);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; strobe = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic step(input logic [3:0] s, input logic [3:0] h, input logic [1:0] p,
                        input logic [1:0] r, input logic [NC-1:0] o, input logic [NTX-1:0] t);
        @(negedge clk);
        sig = s; hi = h; pr = p; rel = r; oc = o; tx = t; strobe = 1;
        @(negedge clk);
        strobe = 0;
    endtask

    task automatic bg();
        step(4'b0101, 4'b0101, 2'b00, 2'b00, '0, '1);
    endtask

    task automatic expect_out(input string tag, input int et, input int er, input int ec);
        chk({tag, " trip"}, int'(trip), et);
        chk({tag, " rule"}, int'(trip_rule), er);
        chk({tag, " cycle"}, int'(trip_cycle), ec);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        do_reset();
        expect_out("R1 reset", 0, 0, 0);

        // R2: strobe 0 is masked, strobe 1 onward is checked
        step(4'b0011, 4'b1111, 2'b00, 2'b00, '0, '1);
        expect_out("R2 boot", 0, 0, 0);
        bg();
        expect_out("R2 warm", 0, 0, 0);
        step(4'b0011, 4'b0011, 2'b00, 2'b00, '0, '1);
        expect_out("R3 AB", 1, 0, 2);

        do_reset();
        bg(); bg();
        step(4'b1100, 4'b1100, 2'b00, 2'b00, '0, '1);
        expect_out("R3 CD", 1, 1, 2);

        do_reset();
        bg(); bg();
        step(4'b0101, 4'b0111, 2'b00, 2'b00, '0, '1);
        expect_out("R4 slow", 1, 3, 2);

        do_reset();
        bg();
        step(4'b0101, 4'b0101, 2'b01, 2'b00, '0, '1);
        expect_out("R5 pre", 0, 0, 0);
        bg();
        expect_out("R5 point", 1, 6, 2);

        do_reset();
        bg();
        step(4'b0100, 4'b0100, 2'b01, 2'b00, '0, '1);
        step(4'b0100, 4'b0100, 2'b01, 2'b00, '0, '1);
        step(4'b0100, 4'b0100, 2'b01, 2'b00, '0, '1);
        expect_out("R10 held", 0, 0, 0);
        step(4'b0101, 4'b0101, 2'b01, 2'b00, '0, '1);
        expect_out("R10 persist", 1, 6, 4);

        do_reset();
        bg();
        step(4'b0101, 4'b0101, 2'b00, 2'b10, '0, '1);
        expect_out("R6 lock", 1, 8, 1);

        do_reset();
        step(4'b0000, 4'b0000, 2'b00, 2'b00, '0, '1);
        step(4'b0000, 4'b0000, 2'b00, 2'b11, '0, '1);
        expect_out("R6 dark", 0, 0, 0);

        do_reset();
        step(4'b0101, 4'b0101, 2'b00, 2'b00, 5'b00110, 4'b1101);
        bg();
        expect_out("R7 early", 0, 0, 0);
        bg();
        expect_out("R7 tx", 1, 10, 2);

        do_reset();
        step(4'b0101, 4'b0101, 2'b00, 2'b00, 5'b00110, 4'b1101);
        step(4'b0101, 4'b0101, 2'b00, 2'b00, 5'b00000, 4'b1111);
        step(4'b0101, 4'b0101, 2'b00, 2'b00, 5'b00000, 4'b1101);
        bg();
        expect_out("R7 quiet", 0, 0, 0);

        do_reset();
        bg();
        step(4'b1101, 4'b1101, 2'b00, 2'b01, '0, '1);
        expect_out("R8 prio", 1, 1, 1);
        step(4'b0011, 4'b0011, 2'b00, 2'b00, '0, '1);
        expect_out("R9 sticky", 1, 1, 1);
        bg();
        expect_out("R9 clean", 1, 1, 1);

        do_reset();
        bg();
        step(4'b0101, 4'b0101, 2'b01, 2'b00, '0, '1);
        @(negedge clk);
        sig = 4'b0011; hi = 4'b0011; rel = 2'b11;
        repeat (5) @(negedge clk);
        expect_out("R11 idle", 0, 0, 0);
        bg();
        expect_out("R11 hist", 1, 6, 2);

        // mixed stimulus against the model
        for (int k = 0; k < 60; k++) begin
            do_reset();
            for (int j = 0; j < 30; j++) begin
                logic [3:0] s;
                logic [3:0] h;
                s = 4'($urandom) & 4'($urandom);
                h = s | (4'($urandom) & 4'($urandom) & 4'($urandom));
                step(s, h, 2'($urandom) & 2'($urandom) & 2'($urandom),
                     2'($urandom) & 2'($urandom) & 2'($urandom),
                     NC'($urandom), NTX'($urandom));
                if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
            end
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule